// File: doc/BRIEF.md
# I2C Slave Read-Phase Flow Controller

This block steers the data phase of a read transaction when the chip acts as a target on an I2C bus. A bit-level engine elsewhere reports the address match (with its R/W bit), asks for each outgoing byte, and reports the controller's acknowledge for each byte. This block answers those events. It takes bytes from a transmit FIFO, requests that SCL be held low when it has nothing to send, and keeps the flags that software polls.

Two transmit styles are supported. In on-demand mode, a read match locks out the FIFO and stretches the clock until software clears the lock and writes data. In preload mode, software fills the FIFO ahead of time and arms a ready bit. Until that bit is set, read addresses are refused, and the bit drops by itself once the first byte has been acknowledged. When clock stretching is disabled, an empty FIFO at a byte boundary is reported as an underrun and an all-ones byte is sent. The controller's NACK ends the read and flushes whatever is left in the FIFO.

Top module: `i2c_slv_tx_flow`

## Requirements
- R1: In on-demand mode (preload_mode=0), an accepted match with addr_rw=1 sets both flag_match and flag_lock on the next clock, and latches rd_dir=1.
- R2: In on-demand mode, after a read match scl_hold stays 1 until flag_lock is clear and fifo_count is non-zero. On that cycle one byte is popped and presented on tx_byte with tx_valid=1, and scl_hold then remains 1 for hi_cnt+1 more sampled cycles before it releases.
- R3: With stretch_dis=0, a byte_req while the FIFO is empty asserts scl_hold and raises no underrun. The byte is popped and sent once data arrives.
- R4: A NACK (ack_valid=1, ack_nack=1) during the data phase sets flag_done and pulses fifo_flush, so the FIFO is empty before the next read.
- R5: In preload mode, while ready_bit=0 a read address is refused: addr_ack=0 and flag_match stays 0.
- R6: In preload mode, an accepted read match sets flag_match but leaves flag_lock at 0, and bytes are sent on byte_req without stretching.
- R7: ready_bit is set by ready_set and clears automatically at the first acknowledge after a byte has been sent in the data phase.
- R8: With stretch_dis=1, a byte_req with an empty FIFO sets flag_unrun and presents tx_byte=8'hFF with tx_valid=1.
- R9: An accepted match with addr_rw=0 sets flag_match and latches rd_dir=0. It neither stretches the clock nor sets flag_lock.
- R10: After reset, every flag, ready_bit, scl_hold and tx_valid read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_hit | input | 1 | Pulse: own address seen on the bus |
| addr_rw | input | 1 | R/W bit that came with addr_hit |
| addr_ack | output | 1 | Acknowledge decision for the address |
| byte_req | input | 1 | Pulse: engine needs the next data byte |
| ack_valid | input | 1 | Pulse: controller acknowledge bit sampled |
| ack_nack | input | 1 | Value of that bit (1 = NACK) |
| fifo_count | input | CNT_W | Transmit FIFO fill level |
| fifo_data | input | 8 | Head byte of the transmit FIFO |
| fifo_pop | output | 1 | Remove the head byte |
| fifo_flush | output | 1 | Discard all FIFO contents |
| stretch_dis | input | 1 | 1 = clock stretching disabled |
| preload_mode | input | 1 | 1 = preload mode, 0 = on-demand mode |
| hi_cnt | input | HI_W | SCL high time, in clocks, counted before release |
| ready_set | input | 1 | Software arms ready_bit |
| lock_clr | input | 1 | Software clears flag_lock |
| clr_flags | input | 1 | Software clears match, done and underrun flags |
| scl_hold | output | 1 | Request to hold SCL low |
| tx_byte | output | 8 | Byte to shift out |
| tx_valid | output | 1 | tx_byte was loaded this cycle |
| ready_bit | output | 1 | Preload ready state |
| rd_dir | output | 1 | Direction latched at the last match |
| flag_match | output | 1 | Address matched |
| flag_lock | output | 1 | Transmit lock-out |
| flag_done | output | 1 | Read ended by NACK |
| flag_unrun | output | 1 | Transmit underrun |

## Verification
A table of preload reads pairs different numbers of preloaded bytes with different numbers of bytes the controller asks for. Equal counts, too few bytes and surplus bytes each give a different mix of real data, 0xFF filler, underrun flag and flushed leftovers. Directed runs cover the rest. The on-demand flow is run with data written before and after the lock is cleared, which tells the lock gate apart from the FIFO-level gate. The high-time count is measured in held cycles, and a mid-read empty FIFO with stretching enabled must stretch rather than underrun. Refused preload reads and write-direction matches show that the flags and the hold request stay untouched.

// File: rtl/i2c_slv_tx_flow.sv
module i2c_slv_tx_flow #(
  parameter int CNT_W = 4,
  parameter int HI_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_hit,
  input  logic             addr_rw,
  output logic             addr_ack,
  input  logic             byte_req,
  input  logic             ack_valid,
  input  logic             ack_nack,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [7:0]       fifo_data,
  output logic             fifo_pop,
  output logic             fifo_flush,
  input  logic             stretch_dis,
  input  logic             preload_mode,
  input  logic [HI_W-1:0]  hi_cnt,
  input  logic             ready_set,
  input  logic             lock_clr,
  input  logic             clr_flags,
  output logic             scl_hold,
  output logic [7:0]       tx_byte,
  output logic             tx_valid,
  output logic             ready_bit,
  output logic             rd_dir,
  output logic             flag_match,
  output logic             flag_lock,
  output logic             flag_done,
  output logic             flag_unrun
);

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_WAIT, S_HIGH} st_t;
  st_t st;
  logic [HI_W-1:0] hcnt;

  logic taken, rd_take, have_data, byte_now, wait_go, under, nack_ev, first_ack;

  assign addr_ack   = !(addr_rw && preload_mode && !ready_bit);
  assign taken      = addr_hit && addr_ack;
  assign rd_take    = taken && addr_rw;
  assign have_data  = (fifo_count != '0) && !flag_lock;
  assign byte_now   = (st == S_ACT) && byte_req;
  assign wait_go    = (st == S_WAIT) && have_data;
  assign under      = byte_now && !have_data && stretch_dis;
  assign nack_ev    = (st == S_ACT) && ack_valid && ack_nack;
  assign first_ack  = (st == S_ACT) && ack_valid && ready_bit;
  assign fifo_pop   = (byte_now && have_data) || wait_go;
  assign fifo_flush = nack_ev;
  assign scl_hold   = (st == S_WAIT) || (st == S_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      hcnt <= '0;
    end else if (taken) begin
      st <= !addr_rw ? S_IDLE : (preload_mode ? S_ACT : S_WAIT);
    end else begin
      case (st)
        S_ACT: begin
          if (nack_ev) st <= S_IDLE;
          else if (byte_now && !have_data && !stretch_dis) st <= S_WAIT;
        end
        S_WAIT: if (have_data) begin
          st   <= S_HIGH;
          hcnt <= hi_cnt;
        end
        S_HIGH: begin
          if (hcnt == '0) st <= S_ACT;
          else hcnt <= hcnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte  <= 8'h00;
      tx_valid <= 1'b0;
    end else begin
      tx_valid <= fifo_pop || under;
      if (fifo_pop) tx_byte <= fifo_data;
      else if (under) tx_byte <= 8'hFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_match <= 1'b0;
      flag_lock  <= 1'b0;
      flag_done  <= 1'b0;
      flag_unrun <= 1'b0;
      ready_bit  <= 1'b0;
      rd_dir     <= 1'b0;
    end else begin
      if (taken) begin
        flag_match <= 1'b1;
        rd_dir     <= addr_rw;
      end else if (clr_flags) flag_match <= 1'b0;
      if (rd_take && !preload_mode) flag_lock <= 1'b1;
      else if (lock_clr) flag_lock <= 1'b0;
      if (nack_ev) flag_done <= 1'b1;
      else if (clr_flags) flag_done <= 1'b0;
      if (under) flag_unrun <= 1'b1;
      else if (clr_flags) flag_unrun <= 1'b0;
      if (ready_set) ready_bit <= 1'b1;
      else if (first_ack) ready_bit <= 1'b0;
    end
  end

  assert_ondemand_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit && addr_rw && !preload_mode |=> flag_lock && flag_match && rd_dir);

  assert_no_empty_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> fifo_count != '0);

  assert_nack_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> flag_done);

  assert_refused_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit && addr_rw && preload_mode && !ready_bit && !flag_match |=> !flag_match);

  assert_preload_nolock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit && addr_rw && preload_mode |=> !$rose(flag_lock));

  assert_ready_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_bit) |-> $past(ack_valid));

  assert_underrun_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_unrun) |-> tx_valid && tx_byte == 8'hFF);

  assert_write_nostretch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit && !addr_rw |=> !scl_hold && !rd_dir);

endmodule

// File: tb/i2c_slv_tx_flow_test.sv
module i2c_slv_tx_flow_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, addr_hit, addr_rw, addr_ack, byte_req, ack_valid, ack_nack;
  logic [3:0] fifo_count;
  logic [7:0] fifo_data;
  logic fifo_pop, fifo_flush, stretch_dis, preload_mode;
  logic [7:0] hi_cnt;
  logic ready_set, lock_clr, clr_flags, scl_hold, tx_valid, ready_bit, rd_dir;
  logic [7:0] tx_byte;
  logic flag_match, flag_lock, flag_done, flag_unrun;

  i2c_slv_tx_flow #(.CNT_W(4), .HI_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .addr_hit(addr_hit), .addr_rw(addr_rw), .addr_ack(addr_ack),
    .byte_req(byte_req), .ack_valid(ack_valid), .ack_nack(ack_nack),
    .fifo_count(fifo_count), .fifo_data(fifo_data), .fifo_pop(fifo_pop), .fifo_flush(fifo_flush),
    .stretch_dis(stretch_dis), .preload_mode(preload_mode), .hi_cnt(hi_cnt),
    .ready_set(ready_set), .lock_clr(lock_clr), .clr_flags(clr_flags),
    .scl_hold(scl_hold), .tx_byte(tx_byte), .tx_valid(tx_valid), .ready_bit(ready_bit),
    .rd_dir(rd_dir), .flag_match(flag_match), .flag_lock(flag_lock),
    .flag_done(flag_done), .flag_unrun(flag_unrun));

  logic [7:0] q [0:15];
  logic push_en;
  logic [7:0] push_val;
  assign fifo_data = q[0];

  always @(posedge clk) begin
    if (fifo_flush) fifo_count <= 0;
    else begin
      if (fifo_pop) for (int i = 0; i < 15; i++) q[i] <= q[i+1];
      if (push_en) q[fifo_count - (fifo_pop ? 4'd1 : 4'd0)] <= push_val;
      fifo_count <= fifo_count - (fifo_pop ? 4'd1 : 4'd0) + (push_en ? 4'd1 : 4'd0);
    end
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask
  task automatic push(input logic [7:0] v);
    push_en = 1; push_val = v; cyc(); push_en = 0;
  endtask
  task automatic hit(input logic rw);
    addr_hit = 1; addr_rw = rw; cyc(); addr_hit = 0;
  endtask
  task automatic ack(input logic nk);
    ack_valid = 1; ack_nack = nk; cyc(); ack_valid = 0; ack_nack = 0;
  endtask
  task automatic pulse_clr(); clr_flags = 1; cyc(); clr_flags = 0; endtask

  // {preloaded bytes, requested bytes}
  localparam logic [7:0] TBL [5] = '{8'h33, 8'h24, 8'h01, 8'h52, 8'h11};

  initial begin
    #400000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; addr_hit = 0; addr_rw = 0; byte_req = 0; ack_valid = 0; ack_nack = 0;
    stretch_dis = 1; preload_mode = 1; hi_cnt = 8'd3; ready_set = 0; lock_clr = 0;
    clr_flags = 0; push_en = 0; push_val = 0; fifo_count = 0;
    for (int i = 0; i < 16; i++) q[i] = 8'h00;
    cyc(); cyc();
    chk({flag_match, flag_lock, flag_done, flag_unrun, ready_bit, scl_hold, tx_valid} == 7'b0,
        "R10 reset", {flag_match, flag_lock, flag_done, flag_unrun, ready_bit, scl_hold, tx_valid}, 0);
    rst_n = 1; cyc();

    foreach (TBL[r]) begin
      int nb = TBL[r][7:4];
      int mb = TBL[r][3:0];
      for (int i = 0; i < nb; i++) push(8'hA0 + 8'(i));
      ready_set = 1; cyc(); ready_set = 0;
      chk(ready_bit, "R7 ready set", ready_bit, 1);
      hit(1);
      chk(flag_match && !flag_lock, "R6 preload match", {flag_match, flag_lock}, 2);
      for (int k = 0; k < mb; k++) begin
        byte_req = 1; cyc(); byte_req = 0;
        chk(tx_valid && !scl_hold, "R6 byte presented", {tx_valid, scl_hold}, 2);
        chk(tx_byte == (k < nb ? 8'hA0 + 8'(k) : 8'hFF), "R8 byte value", tx_byte,
            k < nb ? 8'hA0 + 8'(k) : 8'hFF);
        ack(k == mb - 1);
        if (k == 0) chk(!ready_bit, "R7 ready auto clear", ready_bit, 0);
      end
      chk(flag_done, "R4 done on nack", flag_done, 1);
      chk(flag_unrun == (mb > nb), "R8 underrun flag", flag_unrun, mb > nb);
      chk(fifo_count == 0, "R4 leftovers flushed", fifo_count, 0);
      pulse_clr();
    end

    hit(1);
    chk(!flag_match && !scl_hold, "R5 unready read refused", flag_match, 0);
    addr_hit = 1; addr_rw = 1; #1;
    chk(!addr_ack, "R5 addr_ack low", addr_ack, 0);
    cyc(); addr_hit = 0;

    hit(0);
    chk(flag_match && !rd_dir && !flag_lock && !scl_hold, "R9 write match",
        {flag_match, rd_dir, flag_lock, scl_hold}, 8);
    pulse_clr();

    preload_mode = 0; stretch_dis = 0;
    hit(1);
    chk(flag_match && flag_lock && rd_dir, "R1 on-demand match", {flag_match, flag_lock, rd_dir}, 7);
    chk(scl_hold, "R2 hold after match", scl_hold, 1);
    push(8'h5C);
    cyc();
    chk(scl_hold && !tx_valid, "R2 lock blocks data", {scl_hold, tx_valid}, 2);
    lock_clr = 1; cyc(); lock_clr = 0;
    chk(!flag_lock, "R2 lock cleared", flag_lock, 0);
    cyc();
    chk(tx_valid && tx_byte == 8'h5C, "R2 first byte", tx_byte, 8'h5C);
    begin
      int held = 0;
      for (int i = 0; i < 20 && scl_hold; i++) begin held++; cyc(); end
      chk(held == 4, "R2 high time count", held, 4);
    end
    ack(0);
    byte_req = 1; cyc(); byte_req = 0;
    chk(scl_hold && !flag_unrun && !tx_valid, "R3 empty stretch", {scl_hold, flag_unrun, tx_valid}, 4);
    cyc(); cyc();
    chk(scl_hold, "R3 still stretching", scl_hold, 1);
    push(8'h77);
    cyc();
    chk(tx_valid && tx_byte == 8'h77, "R3 refill sent", tx_byte, 8'h77);
    for (int i = 0; i < 20 && scl_hold; i++) cyc();
    push(8'h11);
    ack(1);
    chk(flag_done && fifo_count == 0, "R4 nack flush", fifo_count, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule